// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Software Force

This block gathers interrupt events from a handful of on-chip peripherals and offers the processor one request: the number of the most urgent level that is waiting and allowed through. There are fifteen levels, numbered 1 to 15. Level 15 is the most urgent. Each peripheral has a fixed level. A one-cycle event pulse from a peripheral latches into a pending bit. Software reads and steers the controller through four word registers on a simple select/write bus.

Any level can also be held active from software through a force register. This lets every level be exercised, including levels that no peripheral drives. When the processor takes an interrupt, it returns the level it accepted on an acknowledge strobe. That clears the matching pending bit and the matching force bit.

The block has no external interrupt pins. Polarity and edge selection are not configurable.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, pending reads 0, force reads 0, mask reads 0x0000FFFE (every level blocked), and `irq_level` is 0.
- R2: Register offsets are 0x48 pending (read-only), 0x4C mask (read-write), 0x50 clear (write-only) and 0x54 force (read-write). Bit N of each register stands for level N. Bit 0, bits 16 to 31 and any unmapped offset read 0.
- R3: A one-cycle pulse sets a pending bit, which is readable in the following cycle. The pulses map to levels as follows: UART error to level 1, UART channel A to level 4, UART channel B to level 5, general-purpose timer to level 12, real-time clock to level 13. Several pulses in one cycle set all of their bits.
- R4: Writing 1 to a bit of the clear register clears that pending bit. Writing 0 to a bit leaves it unchanged. Writes to the pending offset are ignored.
- R5: A source pulse in the same cycle as a clear of its bit leaves the bit set.
- R6: The force register reads back what was written. A forced level requests an interrupt whether or not its pending bit is set.
- R7: A mask bit of 1 blocks its level from requesting.
- R8: `irq_level` is the highest level that is (pending or forced) and not masked. It is 0 when no such level exists.
- R9: An acknowledge with level N clears pending bit N and force bit N. A source pulse in the same cycle keeps the pending bit set. An acknowledge with level 0 changes nothing.
- R10: The clear register reads 0, and a write to it leaves the force register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the peripheral window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| uart_a_evt | input | 1 | UART channel A character event pulse |
| uart_b_evt | input | 1 | UART channel B character event pulse |
| uart_err_evt | input | 1 | UART receive overflow pulse |
| rtc_evt | input | 1 | Real-time clock tick pulse |
| gpt_evt | input | 1 | General-purpose timer pulse |
| irq_level | output | 4 | Requested level, 0 = none |
| irq_ack | input | 1 | Acknowledge strobe from the processor |
| irq_ack_level | input | 4 | Level being acknowledged |

## Verification
The hardest cases to set up from the ports are the same-cycle collisions. One is a peripheral pulse that lands in the very cycle its pending bit is being cleared, either by a register write or by an acknowledge. The other is an acknowledge of a level that is both forced and pending.

The stimulus reaches these cases by driving every input of a cycle from one task call. The collision therefore sits on a single clock edge by construction. It then reads the registers back over the bus and watches `irq_level` while the mask is opened one level at a time.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned OFF_PEND  = 8'h48;
  localparam int unsigned OFF_MASK  = 8'h4C;
  localparam int unsigned OFF_CLR   = 8'h50;
  localparam int unsigned OFF_FORCE = 8'h54;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_LVL = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_LVL:1] set_vec,
  input  logic [NUM_LVL:1] clr_vec,
  input  logic [NUM_LVL:1] ack_vec,
  output logic [NUM_LVL:1] pend
);
  logic [NUM_LVL:1] pend_q;
  logic [NUM_LVL:1] pend_d;

  always_comb begin
    pend_d = (pend_q & ~(clr_vec | ack_vec)) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // A pulse colliding with a clear or acknowledge must still land
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // Clear and acknowledge drop exactly the addressed bits
  assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((clr_vec | ack_vec) & ~set_vec) != '0) |=>
      ((pend_q & $past((clr_vec | ack_vec) & ~set_vec)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_LVL = 15,
  parameter int LVL_W   = 4
) (
  input  logic [NUM_LVL:1]  req_vec,
  output logic [LVL_W-1:0]  level
);
  always_comb begin
    level = '0;
    for (int i = 1; i <= NUM_LVL; i++) begin
      if (req_vec[i]) level = LVL_W'(i);
    end
  end
endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
  import irq_ctl_pkg::*;
#(
  parameter int NUM_LVL = 15,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NUM_LVL:1]  ack_vec,
  input  logic [NUM_LVL:1]  pend,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_LVL:1]  mask,
  output logic [NUM_LVL:1]  force_bits,
  output logic [NUM_LVL:1]  clr_vec
);
  acc_kind_e        acc;
  logic             mask_wr, force_wr, clr_wr;
  logic [NUM_LVL:1] mask_q, mask_d;
  logic [NUM_LVL:1] force_q, force_d;
  logic [NUM_LVL:1] wvec;

  always_comb begin
    if (!bus_sel)    acc = ACC_NONE;
    else if (bus_wr) acc = ACC_WRITE;
    else             acc = ACC_READ;
  end

  assign wvec     = bus_wdata[NUM_LVL:1];
  assign mask_wr  = (acc == ACC_WRITE) && (bus_addr == ADDR_W'(OFF_MASK));
  assign force_wr = (acc == ACC_WRITE) && (bus_addr == ADDR_W'(OFF_FORCE));
  assign clr_wr   = (acc == ACC_WRITE) && (bus_addr == ADDR_W'(OFF_CLR));
  assign clr_vec  = clr_wr ? wvec : '0;

  always_comb begin
    mask_d  = mask_wr ? wvec : mask_q;
    force_d = (force_wr ? wvec : force_q) & ~ack_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      force_q <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_d;
      force_q <= force_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (acc == ACC_READ) begin
      case (bus_addr)
        ADDR_W'(OFF_PEND):  bus_rdata[NUM_LVL:1] = pend;
        ADDR_W'(OFF_MASK):  bus_rdata[NUM_LVL:1] = mask_q;
        ADDR_W'(OFF_FORCE): bus_rdata[NUM_LVL:1] = force_q;
        default:            bus_rdata = '0;
      endcase
    end
  end

  assign mask       = mask_q;
  assign force_bits = force_q;

  // Acknowledge removes the forced copy of the level
  assert_ack_clears_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0) |=> ((force_q & $past(ack_vec)) == '0));

  // Clear writes never reach the force register
  assert_clr_keeps_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ack_vec == '0) |=> (force_q == $past(force_q)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_LVL     = 15,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int LVL_UART_ERR = 1,
  parameter int LVL_UART_A  = 4,
  parameter int LVL_UART_B  = 5,
  parameter int LVL_GPT     = 12,
  parameter int LVL_RTC     = 13,
  localparam int LVL_W      = $clog2(NUM_LVL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              uart_a_evt,
  input  logic              uart_b_evt,
  input  logic              uart_err_evt,
  input  logic              rtc_evt,
  input  logic              gpt_evt,
  output logic [LVL_W-1:0]  irq_level,
  input  logic              irq_ack,
  input  logic [LVL_W-1:0]  irq_ack_level
);
  localparam int NUM_SRC = 5;
  localparam int SRC_LVL [NUM_SRC] =
    '{LVL_UART_A, LVL_UART_B, LVL_UART_ERR, LVL_GPT, LVL_RTC};

  logic [1:0]         rst_sync;
  logic               rst_n_int;
  logic [NUM_SRC-1:0] src_pulse;
  logic [NUM_LVL:1]   set_vec, ack_vec, clr_vec;
  logic [NUM_LVL:1]   pend, mask, force_bits, eff;
  logic [NUM_LVL:0]   eff_full, mask_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  assign src_pulse = {rtc_evt, gpt_evt, uart_err_evt, uart_b_evt, uart_a_evt};

  always_comb begin
    set_vec = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_pulse[s]) set_vec[SRC_LVL[s]] = 1'b1;
    end
  end

  for (genvar g = 1; g <= NUM_LVL; g++) begin : g_ack
    assign ack_vec[g] = irq_ack && (irq_ack_level == LVL_W'(g));
  end

  irq_bus_regs #(.NUM_LVL(NUM_LVL), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ack_vec(ack_vec), .pend(pend),
    .bus_rdata(bus_rdata), .mask(mask), .force_bits(force_bits), .clr_vec(clr_vec)
  );

  irq_pend_bank #(.NUM_LVL(NUM_LVL)) u_pend (
    .clk(clk), .rst_n(rst_n_int), .set_vec(set_vec), .clr_vec(clr_vec),
    .ack_vec(ack_vec), .pend(pend)
  );

  assign eff = (pend | force_bits) & ~mask;

  irq_prio_enc #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_enc (
    .req_vec(eff), .level(irq_level)
  );

  assign eff_full  = {eff, 1'b0};
  assign mask_full = {mask, 1'b0};

  // Chosen level is active and nothing above it is
  assert_level_highest_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (irq_level != '0) |-> ((eff_full >> irq_level) == (NUM_LVL+1)'(1)));

  assert_level_idle_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (irq_level == '0) |-> (eff == '0));

  // A blocked level is never presented
  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (irq_level != '0) |-> !mask_full[irq_level]);
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [4:0]  src;
  logic [3:0]  irq_level;
  logic        irq_ack;
  logic [3:0]  irq_ack_level;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    string       req;
    bit          is_level;
    logic [31:0] exp;
  } exp_item_t;
  exp_item_t sb[$];

  // src bits: 0 UART A (L4), 1 UART B (L5), 2 UART error (L1), 3 GPT (L12), 4 RTC (L13)
  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .uart_a_evt(src[0]), .uart_b_evt(src[1]), .uart_err_evt(src[2]),
    .gpt_evt(src[3]), .rtc_evt(src[4]),
    .irq_level(irq_level), .irq_ack(irq_ack), .irq_ack_level(irq_ack_level)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Monitor: compares queued expectations 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = it.is_level ? {28'd0, irq_level} : bus_rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic cyc(input logic s, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic [4:0] p,
                     input logic ak, input logic [3:0] al);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    src = p; irq_ack = ak; irq_ack_level = al;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d, 5'd0, 1'b0, 4'd0);
  endtask

  task automatic pulse(input logic [4:0] p);
    cyc(1'b0, 1'b0, 8'd0, 32'd0, p, 1'b0, 4'd0);
  endtask

  task automatic ack(input logic [3:0] al, input logic [4:0] p);
    cyc(1'b0, 1'b0, 8'd0, 32'd0, p, 1'b1, al);
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string req);
    exp_item_t it;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    src = '0; irq_ack = 1'b0; irq_ack_level = '0;
    it.req = req; it.is_level = 1'b0; it.exp = e;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_lvl(input logic [3:0] e, input string req);
    exp_item_t it;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    src = '0; irq_ack = 1'b0; irq_ack_level = '0;
    it.req = req; it.is_level = 1'b1; it.exp = {28'd0, e};
    sb.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    src = 0; irq_ack = 0; irq_ack_level = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk_rd(8'h48, 32'h0, "R1 pending after reset");
    chk_rd(8'h4C, 32'h0000FFFE, "R1 mask after reset");
    chk_rd(8'h54, 32'h0, "R1 force after reset");
    chk_lvl(4'd0, "R1 level after reset");

    pulse(5'b00001);
    chk_rd(8'h48, 32'h0010, "R3 UART A sets level 4");
    chk_lvl(4'd0, "R7 masked level gives no request");

    pulse(5'b11110);
    chk_rd(8'h48, 32'h3032, "R3 simultaneous pulses");

    wr(8'h4C, 32'hFFFF_FFCE);
    chk_rd(8'h4C, 32'h0000FFCE, "R2 mask readback upper bits zero");
    chk_lvl(4'd5, "R8 highest unmasked is 5");

    wr(8'h50, 32'h0020);
    chk_rd(8'h48, 32'h3012, "R4 clear level 5");
    chk_lvl(4'd4, "R8 falls to level 4");
    wr(8'h50, 32'h0);
    chk_rd(8'h48, 32'h3012, "R4 zero clear no effect");
    chk_rd(8'h50, 32'h0, "R10 clear reads zero");
    wr(8'h48, 32'hFFFF_FFFF);
    chk_rd(8'h48, 32'h3012, "R4 pending write ignored");

    cyc(1'b1, 1'b1, 8'h50, 32'h0010, 5'b00001, 1'b0, 4'd0);
    chk_rd(8'h48, 32'h3012, "R5 pulse beats clear");

    wr(8'h54, 32'h0040);
    chk_rd(8'h54, 32'h0040, "R6 force readback");
    chk_lvl(4'd4, "R7 forced level 6 still masked");
    wr(8'h4C, 32'hFF8E);
    chk_lvl(4'd6, "R6 forced level requests");

    chk_rd(8'h60, 32'h0, "R2 unmapped offset reads zero");
    wr(8'h54, 32'hFFFF_FFFF);
    chk_rd(8'h54, 32'h0000FFFE, "R2 force bit0 and upper bits zero");
    wr(8'h54, 32'h0040);

    ack(4'd6, 5'd0);
    chk_rd(8'h54, 32'h0, "R9 ack clears force bit");
    chk_rd(8'h48, 32'h3012, "R9 ack 6 leaves pending");
    chk_lvl(4'd4, "R8 level after ack");

    ack(4'd4, 5'b00001);
    chk_rd(8'h48, 32'h3012, "R9 pulse beats ack");
    ack(4'd4, 5'd0);
    chk_rd(8'h48, 32'h3002, "R9 ack clears pending 4");
    chk_lvl(4'd0, "R8 only masked levels left");
    ack(4'd0, 5'd0);
    chk_rd(8'h48, 32'h3002, "R9 ack of level 0 ignored");

    wr(8'h4C, 32'h0);
    chk_lvl(4'd13, "R8 RTC level 13 wins");
    wr(8'h50, 32'h2000);
    chk_lvl(4'd12, "R8 timer level 12 next");

    wr(8'h54, 32'h8000);
    wr(8'h50, 32'hFFFF);
    chk_rd(8'h48, 32'h0, "R4 clear all pending");
    chk_rd(8'h54, 32'h8000, "R10 clear leaves force");
    chk_lvl(4'd15, "R6 forced 15 top priority");
    ack(4'd15, 5'd0);
    chk_lvl(4'd0, "R9 ack 15 removes request");

    pulse(5'b00100);
    chk_lvl(4'd1, "R3 UART error at level 1");

    @(negedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule